// File: doc/BRIEF.md
# Character Display Buffer

This block keeps an eight-character text line for a small status display. Software reaches the line through a little-endian register bus using an 8-byte window: any access of 1, 2, 4 or 8 bytes may start at any byte offset. Bytes that run past the last cell continue at cell 0. Reads use the same byte-to-cell mapping as writes.

Each accepted write makes the block send a complete redraw of the line over a byte stream with a valid/ready handshake. The redraw is a carriage return followed by every cell, starting at cell 0. The display sink signals that it has connected with a one-cycle pulse. The first such pulse after reset makes the block send a line of eight spaces. Any later pulse has no effect.

While a frame is being sent, new writes are held off. Each frame therefore shows the line exactly as it stood when that frame started.

Top module: `char_disp_buf`

## Requirements
- R1: After reset, all eight cells read 0x00, the stream output is not valid, and the bus is ready for a write.
- R2: A write with size code s (0=1, 1=2, 2=4, 3=8 bytes) at offset o puts data byte i (bits 8i+7..8i, byte 0 least significant) into cell (o+i) mod 8, for i below the size. Cells outside that range keep their value.
- R3: A read with size code s at offset o returns cell (o+i) mod 8 in byte lane i for each i below the size, and zero in every higher lane. A read is served in the same cycle and is never stalled.
- R4: Every accepted write, of any size, is followed by a frame of nine bytes: 0x0D, then cells 0 to 7 in that order, holding the values after that write.
- R5: While a frame or a queued blank line is still outstanding, the write-ready output is low and a pending write is not applied. That write is applied and framed only after the outstanding output has drained.
- R6: While the stream output is valid and not accepted, it stays valid and the byte does not change.
- R7: The first sink-connect pulse after reset produces exactly eight 0x20 bytes with no carriage return. Later connect pulses produce no output.
- R8: A connect pulse that arrives during a frame is queued. Its blank line goes out after that frame and before any write that is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busOffset | input | 3 | Byte offset within the window |
| busSize | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| busWdata | input | 64 | Write data, little-endian lanes |
| busReady | output | 1 | Access accepted this cycle |
| busRdata | output | 64 | Read data, little-endian lanes |
| sinkOpen | input | 1 | One-cycle pulse when the display sink connects |
| txValid | output | 1 | Stream byte valid |
| txData | output | 8 | Stream byte |
| txReady | input | 1 | Sink accepts the stream byte |

## Verification
Directed writes cover the cases that tell a correct wraparound apart from a clamped or misordered one:
- a 4-byte write at offset 6 that wraps past the last cell;
- an 8-byte write at offset 3;
- single-byte writes at the window edge.

Each write is followed by reads of other sizes and offsets, so that a lane which is zeroed wrongly, or a cell whose index is off by one, shows up in the read data.

Random sizes, offsets and data are then mixed with random stream backpressure. This exposes frames whose bytes come out of order, bytes that change while stalled, and frames that capture a later write.

Two ordering scenarios are checked separately:
- a connect pulse and a write both arriving during an active frame, which separates correct queueing from lost or reordered output;
- a repeated connect pulse, which must produce no output.

// File: rtl/char_disp_pkg.sv
package char_disp_pkg;
  localparam int CELLS  = 8;
  localparam int IDX_W  = $clog2(CELLS + 1);

  typedef enum logic [1:0] {SZ_1B, SZ_2B, SZ_4B, SZ_8B} accSize_t;

  typedef struct packed {
    logic             wrEn;      // apply bus write to cells
    logic             blankLine; // current frame is the blank line
    logic [IDX_W-1:0] byteIdx;   // position inside current frame
  } dispStrobes_t;
endpackage

// File: rtl/char_disp_ctrl.sv
module char_disp_ctrl
  import char_disp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrReq,
  input  logic         sinkOpen,
  input  logic         txReady,
  output logic         wrReady,
  output logic         txValid,
  output dispStrobes_t strobes
);
  localparam int REFRESH_LAST = CELLS;     // CR + CELLS bytes
  localparam int BLANK_LAST   = CELLS - 1; // CELLS spaces

  logic             busy, kindBlank, inited, blankPend;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = kindBlank ? IDX_W'(BLANK_LAST) : IDX_W'(REFRESH_LAST);
  assign wrReady = !busy && !blankPend;
  assign txValid = busy;

  assign strobes.wrEn      = wrReq && wrReady;
  assign strobes.blankLine = kindBlank;
  assign strobes.byteIdx   = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      kindBlank <= 1'b0;
      inited    <= 1'b0;
      blankPend <= 1'b0;
      idx       <= '0;
    end else begin
      if (sinkOpen && !inited) begin
        inited    <= 1'b1;
        blankPend <= 1'b1;
      end
      if (busy) begin
        if (txReady) begin
          if (idx == lastIdx) begin
            busy <= 1'b0;
            idx  <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end else if (blankPend) begin
        busy      <= 1'b1;
        kindBlank <= 1'b1;
        blankPend <= 1'b0;
        idx       <= '0;
      end else if (strobes.wrEn) begin
        busy      <= 1'b1;
        kindBlank <= 1'b0;
        idx       <= '0;
      end
    end
  end

  // R4: an accepted write opens a refresh frame on the next cycle
  a_r4_write_starts_frame: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (txValid && !strobes.blankLine && strobes.byteIdx == '0));
  // R5: no write is applied while the stream is busy
  a_r5_no_write_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !strobes.wrEn);
  // R6: a stalled byte stays offered
  a_r6_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(strobes.byteIdx)));
  // R7: once initialised the flag never clears, and blank lines need it
  a_r7_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    inited |=> inited);
  a_r7_blank_needs_init: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && strobes.blankLine) |-> inited);
endmodule

// File: rtl/char_disp_datapath.sv
module char_disp_datapath
  import char_disp_pkg::*;
#(
  parameter int NCELLS = CELLS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dispStrobes_t          strobes,
  input  logic [OFS_W-1:0]      offset,
  input  logic [1:0]            sizeCode,
  input  logic [NCELLS*8-1:0]   wdata,
  output logic [NCELLS*8-1:0]   rdata,
  output logic [7:0]            txData
);
  localparam int OFS_W = $clog2(NCELLS);
  localparam int CNT_W = OFS_W + 1;
  localparam logic [7:0] CHAR_CR    = 8'h0D;
  localparam logic [7:0] CHAR_SPACE = 8'h20;

  logic [NCELLS-1:0][7:0] cellArr;
  logic [CNT_W-1:0]       numBytes;

  assign numBytes = CNT_W'(1) << sizeCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellArr <= '0;
    end else if (strobes.wrEn) begin
      for (int c = 0; c < NCELLS; c++) begin
        logic [OFS_W-1:0] lane;
        lane = OFS_W'(c) - offset;
        if (CNT_W'(lane) < numBytes) cellArr[c] <= wdata[lane*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCELLS; i++) begin
      if (CNT_W'(i) < numBytes) rdata[i*8 +: 8] = cellArr[OFS_W'(offset + OFS_W'(i))];
      else                      rdata[i*8 +: 8] = 8'h00;
    end
  end

  always_comb begin
    if (strobes.blankLine)           txData = CHAR_SPACE;
    else if (strobes.byteIdx == '0)  txData = CHAR_CR;
    else                             txData = cellArr[OFS_W'(strobes.byteIdx - 1'b1)];
  end

  // R2: storage changes only through a write strobe
  a_r2_cells_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> $stable(cellArr));
  // R2: a full-width write leaves no cell untouched
  a_r2_full_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && sizeCode == 2'd3 && offset == '0) |=> (cellArr == $past(wdata)));
endmodule

// File: rtl/char_disp_buf.sv
module char_disp_buf
  import char_disp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [2:0]  busOffset,
  input  logic [1:0]  busSize,
  input  logic [63:0] busWdata,
  output logic        busReady,
  output logic [63:0] busRdata,
  input  logic        sinkOpen,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txReady
);
  dispStrobes_t strobes;
  logic         wrReady;

  assign busReady = busWrite ? wrReady : 1'b1;

  char_disp_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .wrReq(busValid && busWrite),
    .sinkOpen(sinkOpen), .txReady(txReady),
    .wrReady(wrReady), .txValid(txValid), .strobes(strobes)
  );

  char_disp_datapath #(.NCELLS(CELLS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .offset(busOffset), .sizeCode(busSize), .wdata(busWdata),
    .rdata(busRdata), .txData(txData)
  );

  // R6: the offered byte is stable while stalled
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData));
  // R3: reads are never stalled
  a_r3_read_ready: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> busReady);
endmodule

// File: tb/tb_char_disp_buf.sv
module tb_char_disp_buf;
  localparam int PERIOD = 10;

  logic        clk = 0, rstN = 0;
  logic        busValid = 0, busWrite = 0;
  logic [2:0]  busOffset = 0;
  logic [1:0]  busSize = 0;
  logic [63:0] busWdata = 0;
  logic        busReady;
  logic [63:0] busRdata;
  logic        sinkOpen = 0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 0;

  int totalCnt = 0, failCnt = 0;
  logic [7:0] model [8];
  logic [7:0] rxQ [$];
  logic [7:0] expQ [$];

  always #(PERIOD/2) clk = ~clk;

  char_disp_buf dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input int ofs, input int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = model[(ofs + i) % 8];
    return r;
  endfunction

  // stream collector with random backpressure; R6 hold check
  initial begin
    bit prevStall = 0;
    logic [7:0] prevData = 0;
    forever begin
      @(negedge clk);
      txReady = ($urandom_range(0, 9) < 7);
      #1;
      if (rstN && prevStall)
        check(txValid && txData == prevData, "R6 stalled byte held", {55'd0, txValid, txData}, {56'd1, prevData});
      if (rstN && txValid && txReady) rxQ.push_back(txData);
      prevStall = rstN && txValid && !txReady;
      prevData  = txData;
    end
  end

  task automatic pushRefresh();
    expQ.push_back(8'h0D);
    for (int c = 0; c < 8; c++) expQ.push_back(model[c]);
  endtask

  task automatic pushBlank();
    for (int c = 0; c < 8; c++) expQ.push_back(8'h20);
  endtask

  task automatic busWr(input int ofs, input int sz, input logic [63:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busOffset = 3'(ofs); busSize = 2'(sz); busWdata = d;
    #2;
    while (!busReady) begin @(negedge clk); #2; end
    @(negedge clk);
    busValid = 0; busWrite = 0;
    for (int i = 0; i < (1 << sz); i++) model[(ofs + i) % 8] = d[i*8 +: 8];
  endtask

  task automatic busRd(input int ofs, input int sz, input string tag);
    @(negedge clk);
    busValid = 1; busWrite = 0; busOffset = 3'(ofs); busSize = 2'(sz);
    #2;
    check(busReady === 1'b1, {tag, " read ready"}, {63'd0, busReady}, 64'd1);
    check(busRdata === expRead(ofs, sz), tag, busRdata, expRead(ofs, sz));
    busValid = 0;
  endtask

  task automatic drain(input string tag);
    int waitCnt = 0;
    while (rxQ.size() < expQ.size() && waitCnt < 400) begin @(negedge clk); waitCnt++; end
    check(rxQ.size() == expQ.size(), {tag, " byte count"}, 64'(rxQ.size()), 64'(expQ.size()));
    for (int k = 0; k < expQ.size() && k < rxQ.size(); k++)
      check(rxQ[k] == expQ[k], {tag, " byte"}, 64'(rxQ[k]), 64'(expQ[k]));
    repeat (15) @(negedge clk);
    check(rxQ.size() == expQ.size(), {tag, " no extra bytes"}, 64'(rxQ.size()), 64'(expQ.size()));
    rxQ.delete(); expQ.delete();
  endtask

  initial begin
    #(PERIOD * 100000);
    totalCnt++; failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) model[c] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    busWrite = 1; #2;
    // R1: reset state
    check(busReady === 1'b1, "R1 write ready", {63'd0, busReady}, 64'd1);
    check(txValid === 1'b0, "R1 stream idle", {63'd0, txValid}, 64'd0);
    busWrite = 0;
    busRd(0, 3, "R1 cells cleared");

    // R2 R4: wrapping 4-byte write at offset 6
    busWr(6, 2, 64'h0000_0000_4433_2211);
    pushRefresh();
    drain("R4 frame after wrap write");
    busRd(7, 1, "R3 wrap read 2B");
    busRd(6, 0, "R3 upper lanes zero");
    busRd(0, 3, "R2 wrap placement");

    // R2: 8-byte write at offset 3
    busWr(3, 3, 64'h4847_4645_4443_4241);
    pushRefresh();
    drain("R4 frame after 8B write");
    busRd(0, 3, "R2 8B offset write");
    busRd(5, 2, "R3 4B read offset 5");

    // R2: single byte at last cell, others keep values
    busWr(7, 0, 64'hFFFF_FFFF_FFFF_FF5A);
    pushRefresh();
    drain("R4 frame after 1B write");
    busRd(0, 3, "R2 1B write keeps others");

    // R5 R8: connect and write during an active frame
    busWr(2, 1, 64'h0000_0000_0000_6261);
    pushRefresh();
    @(negedge clk);
    sinkOpen = 1;
    @(negedge clk);
    sinkOpen = 0;
    busWrite = 1; busValid = 1; busOffset = 3'd0; busSize = 2'd0; busWdata = 64'h7A;
    #2;
    check(busReady === 1'b0, "R5 write stalled during frame", {63'd0, busReady}, 64'd0);
    busWrite = 0; busOffset = 3'd2; busSize = 2'd1;
    #1;
    check(busReady === 1'b1 && busRdata === expRead(2, 1), "R5 read served during frame", busRdata, expRead(2, 1));
    busValid = 0;
    pushBlank();
    busWr(0, 0, 64'h7A);
    pushRefresh();
    drain("R8 frame then blank then write");
    busRd(0, 3, "R5 deferred write applied");

    // R7: repeated connect is ignored
    @(negedge clk); sinkOpen = 1; @(negedge clk); sinkOpen = 0;
    drain("R7 second connect silent");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int ofs = $urandom_range(0, 7);
      int sz  = $urandom_range(0, 3);
      busWr(ofs, sz, {$urandom, $urandom});
      pushRefresh();
      drain("R4 random frame");
      busRd($urandom_range(0, 7), $urandom_range(0, 3), "R3 random read");
    end

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule